// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block is the architectural register store of a 32-bit RISC core that runs in one of seven operating modes. Software always addresses sixteen general registers with a 4-bit index. The current mode, held in the low five bits of the current status word, picks which of 31 physical general registers each index reaches. Index 15 is the program counter and index 14 is the link register.

The block has two combinational read ports and one clocked write port. It also has a dedicated port for loading the program counter, a current status word, and five saved status words, one for each exception mode. Decode, execution and memory logic sit outside the block and drive these ports directly. A mode change written into the status word steers register accesses from the following cycle onward.

Mode codes: user 5'b10000, fast interrupt 5'b10001, interrupt 5'b10010, supervisor 5'b10011, abort 5'b10111, undefined 5'b11011, system 5'b11111.

Top module: `banked_regfile`

## Requirements
- R1: After reset the status word reads 32'h000000D3: mode is supervisor, I (bit 7) and F (bit 6) are set, and T (bit 5) is clear. Every general register, including the program counter, reads zero, and the saved status word reads zero.
- R2: Indices 0 to 7 reach the same physical registers in every mode.
- R3: In fast interrupt mode, indices 8 to 14 reach a private set of registers. Every other mode sees the shared registers at indices 8 to 12.
- R4: Interrupt, supervisor, abort and undefined modes each have their own pair of registers for indices 13 and 14.
- R5: System mode reaches exactly the registers that user mode reaches.
- R6: Index 15 is the program counter. A write port access to index 15 updates pc_out on the next clock edge, and reads of index 15 return it.
- R7: A pc_wr_en load sets the program counter at the next edge. It takes priority over a write port access to index 15 in the same cycle.
- R8: Both read ports are combinational and independent. The same index on both ports returns the same value.
- R9: Status writes keep only N, Z, C, V (bits 31 to 28) and bits 7 to 0; all other bits read zero. A register write issued in the same cycle as a mode change uses the old mode, and the new mode applies from the next cycle.
- R10: Each exception mode has its own saved status word, masked like the status word.
- R11: In user or system mode the saved status port reads zero and writes to it change nothing.
- R12: A mode code outside the seven listed ones uses the user register set and has no saved status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 4 | Read port A index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write port enable |
| wr_idx | input | 4 | Write port index |
| wr_data | input | 32 | Write port data |
| pc_wr_en | input | 1 | Program counter load enable |
| pc_wr_data | input | 32 | Program counter load value |
| pc_out | output | 32 | Current program counter |
| cpsr_wr_en | input | 1 | Status word write enable |
| cpsr_wr_data | input | 32 | Status word write value |
| cpsr_out | output | 32 | Current status word |
| spsr_wr_en | input | 1 | Saved status write enable for the current mode |
| spsr_wr_data | input | 32 | Saved status write value |
| spsr_out | output | 32 | Saved status word of the current mode |

## Verification
Read data depends combinationally on the index and the stored mode, so the bench samples it one time step after changing the index, inside the same cycle. A register, status or saved status write becomes visible only after the next rising edge. The bench therefore drives each write at a falling edge and checks the result at or after the following falling edge. A mode change applies to accesses one cycle later, so a write issued in the same cycle as the change is checked against the bank of the old mode.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int XLEN   = 32;
  localparam int NPHYS  = 31;
  localparam int NSAVED = 5;
  localparam int PW     = $clog2(NPHYS);
  localparam int SW     = $clog2(NSAVED);

  localparam logic [4:0] M_USR = 5'b10000;
  localparam logic [4:0] M_FIQ = 5'b10001;
  localparam logic [4:0] M_IRQ = 5'b10010;
  localparam logic [4:0] M_SVC = 5'b10011;
  localparam logic [4:0] M_ABT = 5'b10111;
  localparam logic [4:0] M_UND = 5'b11011;

  localparam logic [31:0] PSR_KEEP  = 32'hF000_00FF;
  localparam logic [31:0] PSR_RESET = 32'h0000_00D3;

  // physical slot bases for the banked groups
  localparam logic [PW-1:0] B_FIQ = PW'(16);
  localparam logic [PW-1:0] B_IRQ = PW'(23);
  localparam logic [PW-1:0] B_SVC = PW'(25);
  localparam logic [PW-1:0] B_ABT = PW'(27);
  localparam logic [PW-1:0] B_UND = PW'(29);

  function automatic logic [PW-1:0] gpr_phys(input logic [4:0] m, input logic [3:0] r);
    logic [PW-1:0] p;
    logic hi;
    p  = PW'(r);
    hi = (r == 4'd14);
    if (m == M_FIQ && r >= 4'd8 && r <= 4'd14) begin
      p = B_FIQ + PW'(r - 4'd8);
    end else if (r == 4'd13 || r == 4'd14) begin
      case (m)
        M_IRQ:   p = B_IRQ + PW'(hi);
        M_SVC:   p = B_SVC + PW'(hi);
        M_ABT:   p = B_ABT + PW'(hi);
        M_UND:   p = B_UND + PW'(hi);
        default: p = PW'(r);
      endcase
    end
    return p;
  endfunction

  // {valid, slot}
  function automatic logic [SW:0] saved_slot(input logic [4:0] m);
    case (m)
      M_FIQ:   return {1'b1, SW'(0)};
      M_IRQ:   return {1'b1, SW'(1)};
      M_SVC:   return {1'b1, SW'(2)};
      M_ABT:   return {1'b1, SW'(3)};
      M_UND:   return {1'b1, SW'(4)};
      default: return {1'b0, SW'(0)};
    endcase
  endfunction
endpackage

// File: rtl/rf_bank_map.sv
module rf_bank_map
  import rf_pkg::*;
(
  input  logic [4:0]    mode,
  input  logic [3:0]    idx,
  output logic [PW-1:0] phys
);
  always_comb phys = gpr_phys(mode, idx);
endmodule

// File: rtl/rf_gpr_store.sv
module rf_gpr_store
  import rf_pkg::*;
#(
  parameter int DW = XLEN,
  parameter int NP = NPHYS,
  parameter int PC_SLOT = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [$clog2(NP)-1:0] ra_phys,
  input  logic [$clog2(NP)-1:0] rb_phys,
  output logic [DW-1:0]      ra_data,
  output logic [DW-1:0]      rb_data,
  input  logic               wr_en,
  input  logic [$clog2(NP)-1:0] wr_phys,
  input  logic [DW-1:0]      wr_data,
  input  logic               pc_wr_en,
  input  logic [DW-1:0]      pc_wr_data,
  output logic [DW-1:0]      pc_q
);
  logic [DW-1:0] regs [NP];
  logic          pc_port_wins;

  assign pc_port_wins = pc_wr_en && wr_en && (wr_phys == ($clog2(NP))'(PC_SLOT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NP; i++) regs[i] <= '0;
    end else begin
      for (int i = 0; i < NP; i++) begin
        if (pc_wr_en && i == PC_SLOT)
          regs[i] <= pc_wr_data;
        else if (wr_en && wr_phys == ($clog2(NP))'(i))
          regs[i] <= wr_data;
      end
    end
  end

  assign ra_data = regs[ra_phys];
  assign rb_data = regs[rb_phys];
  assign pc_q    = regs[PC_SLOT];

  // R7
  pc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_wr_en |=> pc_q == $past(pc_wr_data));
  // R7
  pc_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_port_wins |=> pc_q != $past(wr_data) || $past(wr_data) == $past(pc_wr_data));
endmodule

// File: rtl/rf_psr_unit.sv
module rf_psr_unit
  import rf_pkg::*;
#(
  parameter int DW = XLEN,
  parameter int NS = NSAVED
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpsr_wr_en,
  input  logic [DW-1:0] cpsr_wr_data,
  output logic [DW-1:0] cpsr_q,
  input  logic          spsr_wr_en,
  input  logic [DW-1:0] spsr_wr_data,
  output logic [DW-1:0] spsr_rd,
  output logic [4:0]    mode
);
  localparam logic [DW-1:0] KEEP = DW'(PSR_KEEP);

  logic [NS-1:0][DW-1:0] spsr_q;
  logic [SW:0]           sel;
  logic                  sel_ok;
  logic [SW-1:0]         sel_slot;
  logic                  spsr_wr_hit;
  logic                  spsr_wr_drop;

  assign mode         = cpsr_q[4:0];
  assign sel          = saved_slot(mode);
  assign sel_ok       = sel[SW];
  assign sel_slot     = sel[SW-1:0];
  assign spsr_wr_hit  = spsr_wr_en && sel_ok;
  assign spsr_wr_drop = spsr_wr_en && !sel_ok;

  always_ff @(posedge clk) begin
    if (!rst_n)          cpsr_q <= DW'(PSR_RESET);
    else if (cpsr_wr_en) cpsr_q <= cpsr_wr_data & KEEP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           spsr_q <= '0;
    else if (spsr_wr_hit) spsr_q[sel_slot] <= spsr_wr_data & KEEP;
  end

  assign spsr_rd = sel_ok ? spsr_q[sel_slot] : '0;

  // R9
  cpsr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpsr_wr_en |=> $stable(cpsr_q));
  // R9
  cpsr_resv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpsr_q & ~KEEP) == '0);
  // R11
  spsr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spsr_wr_drop |=> $stable(spsr_q));
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import rf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  rd_a_idx,
  output logic [31:0] rd_a_data,
  input  logic [3:0]  rd_b_idx,
  output logic [31:0] rd_b_data,
  input  logic        wr_en,
  input  logic [3:0]  wr_idx,
  input  logic [31:0] wr_data,
  input  logic        pc_wr_en,
  input  logic [31:0] pc_wr_data,
  output logic [31:0] pc_out,
  input  logic        cpsr_wr_en,
  input  logic [31:0] cpsr_wr_data,
  output logic [31:0] cpsr_out,
  input  logic        spsr_wr_en,
  input  logic [31:0] spsr_wr_data,
  output logic [31:0] spsr_out
);
  localparam int NPORT = 3; // 0: read A, 1: read B, 2: write

  logic [4:0]    mode;
  logic [3:0]    idx_v  [NPORT];
  logic [PW-1:0] phys_v [NPORT];

  assign idx_v[0] = rd_a_idx;
  assign idx_v[1] = rd_b_idx;
  assign idx_v[2] = wr_idx;

  for (genvar g = 0; g < NPORT; g++) begin : g_map
    rf_bank_map u_map (.mode(mode), .idx(idx_v[g]), .phys(phys_v[g]));
  end

  rf_psr_unit #(.DW(XLEN), .NS(NSAVED)) u_psr (
    .clk(clk), .rst_n(rst_n),
    .cpsr_wr_en(cpsr_wr_en), .cpsr_wr_data(cpsr_wr_data), .cpsr_q(cpsr_out),
    .spsr_wr_en(spsr_wr_en), .spsr_wr_data(spsr_wr_data), .spsr_rd(spsr_out),
    .mode(mode)
  );

  rf_gpr_store #(.DW(XLEN), .NP(NPHYS), .PC_SLOT(15)) u_gpr (
    .clk(clk), .rst_n(rst_n),
    .ra_phys(phys_v[0]), .rb_phys(phys_v[1]),
    .ra_data(rd_a_data), .rb_data(rd_b_data),
    .wr_en(wr_en), .wr_phys(phys_v[2]), .wr_data(wr_data),
    .pc_wr_en(pc_wr_en), .pc_wr_data(pc_wr_data), .pc_q(pc_out)
  );

  // R8
  same_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == rd_b_idx) |-> (rd_a_data == rd_b_data));
  // R6
  pc_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == 4'd15) |-> (rd_a_data == pc_out));
endmodule

// File: tb/banked_regfile_tb.sv
`timescale 1ns/1ps
module banked_regfile_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, pc_out, cpsr_out, spsr_out;
  logic        wr_en = 1'b0, pc_wr_en = 1'b0, cpsr_wr_en = 1'b0, spsr_wr_en = 1'b0;
  logic [31:0] wr_data = '0, pc_wr_data = '0, cpsr_wr_data = '0, spsr_wr_data = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  banked_regfile u_dut (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .pc_wr_en(pc_wr_en), .pc_wr_data(pc_wr_data), .pc_out(pc_out),
    .cpsr_wr_en(cpsr_wr_en), .cpsr_wr_data(cpsr_wr_data), .cpsr_out(cpsr_out),
    .spsr_wr_en(spsr_wr_en), .spsr_wr_data(spsr_wr_data), .spsr_out(spsr_out)
  );

  localparam logic [4:0] USR = 5'h10, FIQ = 5'h11, IRQ = 5'h12, SVC = 5'h13,
                         ABT = 5'h17, UND = 5'h1B, SYS = 5'h1F;

  // row: op[46:45] (0 mode, 1 write, 2 read-check), mode[44:40], idx[39:36],
  //      data[35:4], requirement number[3:0]
  localparam int NV = 34;
  localparam logic [46:0] VECS [NV] = '{
    {2'd0, USR, 4'd0,  32'h0,         4'd0},
    {2'd1, USR, 4'd0,  32'h1000_0000, 4'd0},
    {2'd1, USR, 4'd8,  32'h1000_0008, 4'd0},
    {2'd1, USR, 4'd13, 32'h1000_000D, 4'd0},
    {2'd1, USR, 4'd14, 32'h1000_000E, 4'd0},
    {2'd0, FIQ, 4'd0,  32'h0,         4'd0},
    {2'd1, FIQ, 4'd8,  32'h2000_0008, 4'd0},
    {2'd1, FIQ, 4'd13, 32'h2000_000D, 4'd0},
    {2'd2, FIQ, 4'd0,  32'h1000_0000, 4'd2},  // R2
    {2'd2, FIQ, 4'd8,  32'h2000_0008, 4'd3},  // R3
    {2'd0, IRQ, 4'd0,  32'h0,         4'd0},
    {2'd1, IRQ, 4'd13, 32'h3000_000D, 4'd0},
    {2'd2, IRQ, 4'd8,  32'h1000_0008, 4'd3},  // R3
    {2'd2, IRQ, 4'd13, 32'h3000_000D, 4'd4},  // R4
    {2'd2, IRQ, 4'd14, 32'h0,         4'd4},  // R4
    {2'd0, SVC, 4'd0,  32'h0,         4'd0},
    {2'd1, SVC, 4'd14, 32'h4000_000E, 4'd0},
    {2'd2, SVC, 4'd13, 32'h0,         4'd4},  // R4
    {2'd0, ABT, 4'd0,  32'h0,         4'd0},
    {2'd1, ABT, 4'd13, 32'h5000_000D, 4'd0},
    {2'd2, ABT, 4'd14, 32'h0,         4'd4},  // R4
    {2'd0, UND, 4'd0,  32'h0,         4'd0},
    {2'd2, UND, 4'd13, 32'h0,         4'd4},  // R4
    {2'd2, UND, 4'd0,  32'h1000_0000, 4'd2},  // R2
    {2'd0, SYS, 4'd0,  32'h0,         4'd0},
    {2'd2, SYS, 4'd13, 32'h1000_000D, 4'd5},  // R5
    {2'd2, SYS, 4'd14, 32'h1000_000E, 4'd5},  // R5
    {2'd1, SYS, 4'd0,  32'h7777_0000, 4'd0},
    {2'd0, USR, 4'd0,  32'h0,         4'd0},
    {2'd2, USR, 4'd0,  32'h7777_0000, 4'd5},  // R5
    {2'd0, FIQ, 4'd0,  32'h0,         4'd0},
    {2'd2, FIQ, 4'd14, 32'h0,         4'd3},  // R3
    {2'd0, SVC, 4'd0,  32'h0,         4'd0},
    {2'd2, SVC, 4'd14, 32'h4000_000E, 4'd4}   // R4
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic set_mode(input logic [4:0] m);
    @(negedge clk);
    cpsr_wr_en = 1'b1; cpsr_wr_data = 32'hC0 | {27'd0, m};
    @(negedge clk);
    cpsr_wr_en = 1'b0;
  endtask

  task automatic wr_reg(input logic [3:0] i, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = i; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_spsr(input logic [31:0] d);
    @(negedge clk);
    spsr_wr_en = 1'b1; spsr_wr_data = d;
    @(negedge clk);
    spsr_wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] i, input logic [31:0] exp);
    rd_a_idx = i; rd_b_idx = i;
    #1;
    check(req, $sformatf("port A idx %0d", i), rd_a_data, exp);
    check(req, $sformatf("port B idx %0d", i), rd_b_data, exp);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "cpsr", cpsr_out, 32'h0000_00D3);
    check("R1", "pc", pc_out, 32'h0);
    check("R1", "spsr", spsr_out, 32'h0);
    rd_chk("R1", 4'd5, 32'h0);
    rd_chk("R1", 4'd14, 32'h0);

    // table walk: banking across modes (R2..R5)
    for (int k = 0; k < NV; k++) begin
      logic [46:0] v;
      v = VECS[k];
      case (v[46:45])
        2'd0: set_mode(v[44:40]);
        2'd1: wr_reg(v[39:36], v[35:4]);
        default: rd_chk($sformatf("R%0d", v[3:0]), v[39:36], v[35:4]);
      endcase
    end

    // R6 write port to index 15
    wr_reg(4'd15, 32'h0000_0100);
    check("R6", "pc after write port", pc_out, 32'h0000_0100);
    rd_chk("R6", 4'd15, 32'h0000_0100);

    // R7 program counter load beats write port
    @(negedge clk);
    pc_wr_en = 1'b1; pc_wr_data = 32'h0000_0200;
    wr_en = 1'b1; wr_idx = 4'd15; wr_data = 32'h0000_0300;
    @(negedge clk);
    pc_wr_en = 1'b0; wr_en = 1'b0;
    check("R7", "pc priority", pc_out, 32'h0000_0200);
    @(negedge clk);
    pc_wr_en = 1'b1; pc_wr_data = 32'h0000_0400;
    @(negedge clk);
    pc_wr_en = 1'b0;
    rd_chk("R7", 4'd15, 32'h0000_0400);

    // R9 masking and old-mode write in the switching cycle
    set_mode(USR);
    @(negedge clk);
    cpsr_wr_en = 1'b1; cpsr_wr_data = 32'hFFFF_FFF1;
    wr_en = 1'b1; wr_idx = 4'd8; wr_data = 32'hAAAA_0008;
    @(negedge clk);
    cpsr_wr_en = 1'b0; wr_en = 1'b0;
    check("R9", "cpsr masked", cpsr_out, 32'hF000_00F1);
    rd_chk("R9", 4'd8, 32'h2000_0008);
    set_mode(USR);
    rd_chk("R9", 4'd8, 32'hAAAA_0008);

    // R10 separate saved status per exception mode
    set_mode(SVC);
    wr_spsr(32'h1234_5613);
    set_mode(IRQ);
    wr_spsr(32'h8000_00D2);
    check("R10", "irq spsr", spsr_out, 32'h8000_00D2);
    set_mode(SVC);
    check("R10", "svc spsr masked", spsr_out, 32'h1000_0013);
    set_mode(FIQ);
    check("R10", "fiq spsr untouched", spsr_out, 32'h0);

    // R11 no saved status in user/system
    set_mode(USR);
    wr_spsr(32'hFFFF_FFFF);
    check("R11", "usr spsr", spsr_out, 32'h0);
    set_mode(SYS);
    wr_spsr(32'hFFFF_FFFF);
    check("R11", "sys spsr", spsr_out, 32'h0);
    set_mode(SVC);
    check("R11", "svc spsr after dropped writes", spsr_out, 32'h1000_0013);
    set_mode(IRQ);
    check("R11", "irq spsr after dropped writes", spsr_out, 32'h8000_00D2);

    // R12 unknown mode code
    @(negedge clk);
    cpsr_wr_en = 1'b1; cpsr_wr_data = 32'h0000_0000;
    @(negedge clk);
    cpsr_wr_en = 1'b0;
    rd_chk("R12", 4'd13, 32'h1000_000D);
    check("R12", "spsr in unknown mode", spsr_out, 32'h0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule